// File: doc/BRIEF.md
# CPU Interrupt State Controller

This block holds the interrupt state of a small 8-bit CPU core. It keeps two interrupt enable flags: a primary enable, which gates maskable requests, and a shadow enable, which remembers the previous setting across a non-maskable entry. It also holds a three-way interrupt mode register. The sequencer drives control strobes into it and a pulse at the start of every opcode fetch. At that pulse the block decides whether to begin a non-maskable entry, a maskable entry, or neither.

The non-maskable line is edge sensitive. A rising edge arms a pending latch, and the latch stays set until the entry is taken. The maskable line is level sensitive and is gated by the primary enable, by a suppression input and by any entry already in progress. An enable write takes effect on the shadow flag first and on the primary flag one cycle later. This gives the one-instruction delay expected after an enable instruction. A restore write copies the shadow flag back into the primary flag. The in-progress indicators stay high until the sequencer signals that the entry sequence is finished.

Top module: `irq_state_ctl`

## Requirements
- R1: On a mode write, data 2'b10 selects mode 1 (`im1`=1, `im2`=0) and 2'b11 selects mode 2 (`im1`=0, `im2`=1). Data 2'b00 or 2'b01 selects mode 0, in which both flags are low.
- R2: A mode write shows on `im1`/`im2` after the clock edge that samples the strobe. While `mode_we` is low the mode is held, whatever `mode_data` carries.
- R3: While `rst_n` is low, and on the first cycle after it is released, `iff1`, `iff2`, `im1`, `im2`, `in_nmi` and `in_intr` all read 0.
- R4: A flag write with `flag_pair`=1 and `flag_bit`=1 sets `iff2` at the first edge and `iff1` at the edge after that. With `flag_bit`=0 the same write clears both flags at the first edge.
- R5: At an `m1_start` pulse with a non-maskable request pending, `iff1` clears, `iff2` keeps its value and `in_nmi` rises, all at that edge. The pending request is then consumed.
- R6: At an `m1_start` pulse with `int_req`=1, `iff1`=1, no non-maskable request pending, `no_int`=0 and no entry in progress, the request is accepted. At that edge `in_intr` rises and both `iff1` and `iff2` clear.
- R7: A maskable request is not accepted, and the flags are unchanged, when `iff1`=0, when `no_int`=1, or while an entry is in progress.
- R8: `in_nmi` and `in_intr` are never high together. When both requests are present at one `m1_start`, the non-maskable entry is taken.
- R9: `seq_done` clears `in_nmi` and `in_intr` at the next edge.
- R10: A flag write with `flag_pair`=0 copies `iff2` into `iff1` at the next edge.
- R11: A pending non-maskable request is armed only by a 0-to-1 transition of `nmi_req`. A level held high after its entry has been taken starts no second entry. An edge that arrives in the same cycle as `m1_start` is taken at the next `m1_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_we | input | 1 | Mode register write strobe |
| mode_data | input | 2 | Mode select field |
| flag_we | input | 1 | Enable flag write strobe |
| flag_pair | input | 1 | 1: write both flags from `flag_bit`; 0: copy shadow into primary |
| flag_bit | input | 1 | Value for a paired flag write |
| nmi_req | input | 1 | Non-maskable request, rising-edge sensitive |
| int_req | input | 1 | Maskable request, level sensitive |
| m1_start | input | 1 | Opcode fetch start pulse (acceptance point) |
| no_int | input | 1 | Suppresses maskable acceptance |
| seq_done | input | 1 | Entry sequence finished |
| iff1 | output | 1 | Primary enable flag |
| iff2 | output | 1 | Shadow enable flag |
| im1 | output | 1 | Mode 1 selected |
| im2 | output | 1 | Mode 2 selected |
| in_nmi | output | 1 | Non-maskable entry in progress |
| in_intr | output | 1 | Maskable entry in progress |

## Verification
The two functions that can meet in one cycle are non-maskable acceptance and maskable acceptance. Both are decided at the same `m1_start` pulse, and either can also fall together with an enable write. The bench raises `nmi_req` and `int_req` in the same cycle while `iff1` is 1, and then pulses `m1_start`. It judges the outcome by checking that only `in_nmi` rises, that `iff2` stays 1 and that `iff1` drops. A second case raises the edge in the very cycle of `m1_start`, and the bench checks that the entry is deferred to the following pulse.

// File: rtl/irq_state_pkg.sv
package irq_state_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_0 = 2'd0,
        MODE_1 = 2'd1,
        MODE_2 = 2'd2
    } irq_mode_e;

    localparam logic [MODE_W-1:0] SEL_MODE_1 = 2'b10;
    localparam logic [MODE_W-1:0] SEL_MODE_2 = 2'b11;

    typedef struct packed {
        logic iff1;
        logic iff2;
        logic ei_arm;
        logic in_nmi;
        logic in_intr;
    } en_state_t;

    typedef struct packed {
        logic prev;
        logic pend;
    } nmi_state_t;
endpackage

// File: rtl/irq_mode_reg.sv
module irq_mode_reg
    import irq_state_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_data,
    output logic              im1,
    output logic              im2
);
    irq_mode_e mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (mode_we) begin
            case (mode_data)
                SEL_MODE_1: mode_d = MODE_1;
                SEL_MODE_2: mode_d = MODE_2;
                default:    mode_d = MODE_0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_0;
        else        mode_q <= mode_d;
    end

    assign im1 = (mode_q == MODE_1);
    assign im2 = (mode_q == MODE_2);

    AST_MODE_SEL1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we && mode_data == SEL_MODE_1 |=> im1 && !im2); // R1
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_we |=> $stable(im1) && $stable(im2)); // R2
endmodule

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch
    import irq_state_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_req,
    input  logic nmi_take,
    output logic nmi_pend
);
    nmi_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = nmi_req;
        if (nmi_take)
            s_d.pend = 1'b0;
        if (nmi_req && !s_q.prev)
            s_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign nmi_pend = s_q.pend;

    AST_NMI_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_pend) |-> $past(nmi_req) && !$past(s_q.prev)); // R11
endmodule

// File: rtl/irq_enable_arb.sv
module irq_enable_arb
    import irq_state_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flag_we,
    input  logic flag_pair,
    input  logic flag_bit,
    input  logic int_req,
    input  logic m1_start,
    input  logic no_int,
    input  logic seq_done,
    input  logic nmi_pend,
    output logic nmi_take,
    output logic iff1,
    output logic iff2,
    output logic in_nmi,
    output logic in_intr
);
    en_state_t s_d, s_q;
    logic      busy;
    logic      int_take;

    always_comb begin
        s_d      = s_q;
        nmi_take = 1'b0;
        int_take = 1'b0;
        busy     = s_q.in_nmi | s_q.in_intr;

        if (seq_done) begin
            s_d.in_nmi  = 1'b0;
            s_d.in_intr = 1'b0;
        end

        if (s_q.ei_arm) begin
            s_d.iff1   = 1'b1;
            s_d.ei_arm = 1'b0;
        end

        if (flag_we) begin
            if (flag_pair) begin
                if (flag_bit) begin
                    s_d.iff2   = 1'b1;
                    s_d.ei_arm = 1'b1;
                end else begin
                    s_d.iff1   = 1'b0;
                    s_d.iff2   = 1'b0;
                    s_d.ei_arm = 1'b0;
                end
            end else begin
                s_d.iff1 = s_q.iff2;
            end
        end

        if (m1_start && !busy) begin
            if (nmi_pend) begin
                nmi_take    = 1'b1;
                s_d.iff1    = 1'b0;
                s_d.iff2    = s_q.iff2;
                s_d.ei_arm  = 1'b0;
                s_d.in_nmi  = 1'b1;
            end else if (int_req && s_q.iff1 && !no_int) begin
                int_take    = 1'b1;
                s_d.iff1    = 1'b0;
                s_d.iff2    = 1'b0;
                s_d.ei_arm  = 1'b0;
                s_d.in_intr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign iff1    = s_q.iff1;
    assign iff2    = s_q.iff2;
    assign in_nmi  = s_q.in_nmi;
    assign in_intr = s_q.in_intr;

    AST_EI_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iff1) |-> $past(iff2)); // R4
    AST_NMI_KEEP_IFF2: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_take |=> !iff1 && in_nmi && iff2 == $past(iff2)); // R5
    AST_INT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_intr) |-> $past(iff1) && !$past(no_int) && !iff1 && !iff2); // R6
    AST_INT_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !seq_done |=> !$rose(in_intr) && !$rose(in_nmi)); // R7
    AST_SEQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_nmi && in_intr)); // R8
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done && !m1_start |=> !in_nmi && !in_intr); // R9
    AST_TAKE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nmi_take, int_take})); // R8
endmodule

// File: rtl/irq_state_ctl.sv
module irq_state_ctl
    import irq_state_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_data,
    input  logic              flag_we,
    input  logic              flag_pair,
    input  logic              flag_bit,
    input  logic              nmi_req,
    input  logic              int_req,
    input  logic              m1_start,
    input  logic              no_int,
    input  logic              seq_done,
    output logic              iff1,
    output logic              iff2,
    output logic              im1,
    output logic              im2,
    output logic              in_nmi,
    output logic              in_intr
);
    logic nmi_pend;
    logic nmi_take;

    irq_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_we   (mode_we),
        .mode_data (mode_data),
        .im1       (im1),
        .im2       (im2)
    );

    irq_nmi_latch u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_req  (nmi_req),
        .nmi_take (nmi_take),
        .nmi_pend (nmi_pend)
    );

    irq_enable_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag_we   (flag_we),
        .flag_pair (flag_pair),
        .flag_bit  (flag_bit),
        .int_req   (int_req),
        .m1_start  (m1_start),
        .no_int    (no_int),
        .seq_done  (seq_done),
        .nmi_pend  (nmi_pend),
        .nmi_take  (nmi_take),
        .iff1      (iff1),
        .iff2      (iff2),
        .in_nmi    (in_nmi),
        .in_intr   (in_intr)
    );
endmodule

// File: tb/irq_state_ctl_tb.sv
`timescale 1ns/1ps
module irq_state_ctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_we = 0, flag_we = 0, flag_pair = 0, flag_bit = 0;
    logic [1:0] mode_data = 0;
    logic       nmi_req = 0, int_req = 0, m1_start = 0, no_int = 0, seq_done = 0;
    logic       iff1, iff2, im1, im2, in_nmi, in_intr;

    int         n_run = 0;
    int         n_fail = 0;
    bit         finished = 0;

    logic [5:0] q_exp[$];
    string      q_tag[$];

    always #2 clk = ~clk;

    irq_state_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_data(mode_data),
        .flag_we(flag_we), .flag_pair(flag_pair), .flag_bit(flag_bit),
        .nmi_req(nmi_req), .int_req(int_req), .m1_start(m1_start),
        .no_int(no_int), .seq_done(seq_done), .iff1(iff1), .iff2(iff2),
        .im1(im1), .im2(im2), .in_nmi(in_nmi), .in_intr(in_intr)
    );

    function automatic logic [5:0] outs();
        return {iff1, iff2, im1, im2, in_nmi, in_intr};
    endfunction

    task automatic compare(input logic [5:0] exp, input string tag);
        n_run++;
        if (outs() !== exp) begin
            n_fail++;
            $display("FAIL %s: {iff1,iff2,im1,im2,in_nmi,in_intr} actual %b expected %b",
                     tag, outs(), exp);
        end
    endtask

    // monitor: pops one expected item per clock, just after the edge
    always @(posedge clk) begin
        #1;
        if (q_exp.size() > 0) compare(q_exp.pop_front(), q_tag.pop_front());
    end

    // driver: apply inputs at negedge, queue the state expected after the next edge
    task automatic step(input logic mw, input logic [1:0] md, input logic fw,
                        input logic fp, input logic fb, input logic nmi,
                        input logic irq, input logic m1, input logic ni,
                        input logic dn, input logic [5:0] exp, input string tag);
        @(negedge clk);
        mode_we = mw; mode_data = md; flag_we = fw; flag_pair = fp; flag_bit = fb;
        nmi_req = nmi; int_req = irq; m1_start = m1; no_int = ni; seq_done = dn;
        q_exp.push_back(exp);
        q_tag.push_back(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 compare(6'b000000, "R3 during reset");
        @(negedge clk) rst_n = 1'b1;
        //          mw md    fw fp fb nmi irq m1 ni dn   expected
        step(0, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 6'b000000, "R3 after release");
        step(1, 2'b10, 0, 0, 0, 0, 0, 0, 0, 0, 6'b001000, "R1 select mode 1");
        step(0, 2'b11, 0, 0, 0, 0, 0, 0, 0, 0, 6'b001000, "R2 mode held without strobe");
        step(1, 2'b11, 0, 0, 0, 0, 0, 0, 0, 0, 6'b000100, "R1 select mode 2");
        step(1, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 6'b000000, "R1 select mode 0");
        step(1, 2'b10, 0, 0, 0, 0, 0, 0, 0, 0, 6'b001000, "R2 mode 1 again");
        step(1, 2'b01, 0, 0, 0, 0, 0, 0, 0, 0, 6'b000000, "R1 code 01 gives mode 0");
        step(1, 2'b10, 0, 0, 0, 0, 0, 0, 0, 0, 6'b001000, "R1 back to mode 1");
        step(0, 2'b00, 0, 0, 0, 0, 1, 1, 0, 0, 6'b001000, "R7 blocked while iff1 low");
        step(0, 2'b00, 1, 1, 1, 0, 0, 0, 0, 0, 6'b011000, "R4 shadow set first");
        step(0, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 6'b111000, "R4 primary one cycle later");
        step(0, 2'b00, 0, 0, 0, 0, 1, 1, 1, 0, 6'b111000, "R7 blocked by no_int");
        step(0, 2'b00, 0, 0, 0, 0, 1, 1, 0, 0, 6'b001001, "R6 maskable accepted");
        step(0, 2'b00, 0, 0, 0, 0, 1, 1, 0, 0, 6'b001001, "R7 no retake while busy");
        step(0, 2'b00, 0, 0, 0, 0, 0, 0, 0, 1, 6'b001000, "R9 done clears in_intr");
        step(0, 2'b00, 0, 0, 0, 0, 1, 1, 0, 0, 6'b001000, "R7 iff1 cleared by acceptance");
        step(0, 2'b00, 1, 1, 1, 0, 0, 0, 0, 0, 6'b011000, "R4 enable again, shadow");
        step(0, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 6'b111000, "R4 enable again, primary");
        step(0, 2'b00, 0, 0, 0, 1, 1, 0, 0, 0, 6'b111000, "R11 edge latched, no entry yet");
        step(0, 2'b00, 0, 0, 0, 1, 1, 1, 0, 0, 6'b011010, "R8 NMI wins over maskable");
        step(0, 2'b00, 0, 0, 0, 1, 0, 0, 0, 1, 6'b011000, "R9 done clears in_nmi");
        step(0, 2'b00, 0, 0, 0, 1, 0, 1, 0, 0, 6'b011000, "R11 held level no retrigger");
        step(0, 2'b00, 1, 0, 0, 1, 0, 0, 0, 0, 6'b111000, "R10 restore iff1 from iff2");
        step(0, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 6'b111000, "R11 line low");
        step(0, 2'b00, 0, 0, 0, 1, 0, 1, 0, 0, 6'b111000, "R11 edge with m1 deferred");
        step(0, 2'b00, 0, 0, 0, 1, 0, 1, 0, 0, 6'b011010, "R5 NMI clears iff1 keeps iff2");
        step(0, 2'b00, 0, 0, 0, 0, 0, 0, 0, 1, 6'b011000, "R9 done after NMI");
        step(0, 2'b00, 1, 1, 0, 0, 0, 0, 0, 0, 6'b001000, "R4 disable clears both");
        step(0, 2'b00, 1, 0, 0, 0, 0, 0, 0, 0, 6'b001000, "R10 restore copies zero");
        step(0, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 6'b001000, "R2 idle end");
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule